// File: doc/BRIEF.md
# Trace Capture Ring Buffer Sink

This block is the final stop of an on-chip trace path. While capture is enabled it writes each valid 32-bit trace word into a circular on-chip RAM, advancing a write pointer that wraps modulo the RAM depth. A full flag records that the pointer has gone round at least once, so the oldest surviving word then sits at the write pointer. Software reads the captured words back through a small register window. A read-data port returns the word under a read pointer and steps the pointer. A write-data port stores a word under the write pointer and steps it, which is how software clears the RAM between runs.

Two mechanisms end a capture cleanly on a frame boundary of four words. The first stops on a trigger: after a trigger, the block stores a programmed number of further words and then stops. The second is a flush, requested by software or by a pin: the block pads the current frame with zero words and then reports completion. It can optionally stop as well. Both mechanisms leave the write pointer on a multiple of four, so a decoder can align to frames.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset the depth register (0x004) reads DEPTH, and status (0x00C), read pointer (0x014), write pointer (0x018), control (0x020), formatter status (0x300) and formatter control (0x304) all read 0. Every read returns its value on `bus_rdata` from the clock edge that samples `bus_rd`. The value holds until the next read.
- R2: While control bit 0 is 1 and the block is not stopped, each cycle with `trc_valid` high stores `trc_data` at the write pointer, and the pointer advances by one modulo DEPTH. Trace words are dropped, with the pointer unchanged, when bit 0 is 0 or the block is stopped.
- R3: Status bit 0 becomes 1 when any RAM write moves the write pointer from DEPTH-1 to 0. Only a write to the write-pointer register (0x018) clears it. A write to that register also loads the pointer and takes priority over an advance in the same cycle.
- R4: A bus write to the write-data port (0x024) stores the word at the write pointer and advances the pointer only while capture is not live. While capture is live the write is ignored and the pointer does not move.
- R5: A bus read of the read-data port (0x010) returns the RAM word at the read pointer and advances the pointer modulo DEPTH. The read pointer can be loaded at 0x014.
- R6: With formatter-control bit 13 set, a `trig_in` seen during live capture starts a count of the value in the trigger-count register (0x01C). The word stored in the trigger cycle does not count. After that many more words are stored, capture pads zero words until the write pointer is a multiple of 4, then stops, and formatter-status bit 1 reads 1.
- R7: Writing formatter-control bit 6 as 1, or a high cycle on `flush_req`, starts a flush, and bit 6 reads 1 until the flush completes. A flush first takes one cycle in which trace words are dropped. Then, if capture is live, it writes zero words until the write pointer is a multiple of 4. Then bit 6 clears.
- R8: If formatter-control bit 12 is set when a flush completes, the block stops, so formatter-status bit 1 reads 1 and further trace words are dropped.
- R9: Writing control bit 0 as 1 while it reads 0 clears the stopped state and forgets any earlier trigger.
- R10: With formatter-control bit 13 clear, `trig_in` has no effect and capture continues with no limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trig_in | input | 1 | Trigger event |
| flush_req | input | 1 | Flush request pulse |

## Verification
The bench drives data-port writes that cross the end of RAM. A design that failed to wrap, or that did not set or clear the full flag at the right moment, would show a wrong pointer or status. It runs a trigger stop that lands three words into a frame and checks both the exact stop pointer and the zero word written after the last real word. An off-by-one count of post-trigger words, or missing padding, would move that pointer. Flushes are started from an unaligned pointer, from an aligned pointer through the pin, and with stop-on-flush set. A bus data write during live capture, trace words sent while disabled or stopped, and a trigger sent with stop-on-trigger clear must all leave the pointer where the reference model puts it.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam logic [11:0] OFS_DEPTH  = 12'h004;
  localparam logic [11:0] OFS_STAT   = 12'h00C;
  localparam logic [11:0] OFS_RDATA  = 12'h010;
  localparam logic [11:0] OFS_RPTR   = 12'h014;
  localparam logic [11:0] OFS_WPTR   = 12'h018;
  localparam logic [11:0] OFS_TRGCNT = 12'h01C;
  localparam logic [11:0] OFS_CTRL   = 12'h020;
  localparam logic [11:0] OFS_WDATA  = 12'h024;
  localparam logic [11:0] OFS_FSTAT  = 12'h300;
  localparam logic [11:0] OFS_FCTRL  = 12'h304;

  localparam int FCTRL_FLUSH_BIT = 6;
  localparam int FCTRL_STOPFL_BIT = 12;
  localparam int FCTRL_STOPTRG_BIT = 13;
  localparam int FSTAT_STOPPED_BIT = 1;
  localparam int FRAME_WORDS = 4;

  typedef enum logic [0:0] {ST_RUN = 1'b0, ST_PAD = 1'b1} cap_state_e;

  function automatic logic on_frame_edge(input logic [31:0] ptr);
    return (ptr % FRAME_WORDS) == 0;
  endfunction

  function automatic logic [31:0] fctrl_word(input logic stop_trg, input logic stop_fl,
                                             input logic busy);
    logic [31:0] v;
    v = '0;
    v[FCTRL_STOPTRG_BIT] = stop_trg;
    v[FCTRL_STOPFL_BIT]  = stop_fl;
    v[FCTRL_FLUSH_BIT]   = busy;
    return v;
  endfunction
endpackage

// File: rtl/trs_ring_ram.sv
module trs_ring_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trs_regfile.sv
module trs_regfile
  import trs_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int AW     = $clog2(DEPTH),
  parameter int TRG_W  = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [AW-1:0]     wptr,
  input  logic              full,
  input  logic              stopped,
  input  logic              flush_busy,
  input  logic [31:0]       ram_q,
  output logic [AW-1:0]     rptr,
  output logic              ctl_en,
  output logic              en_rise,
  output logic              stop_on_trig,
  output logic              stop_on_flush,
  output logic              flush_set,
  output logic              wptr_load,
  output logic [AW-1:0]     wptr_val,
  output logic [TRG_W-1:0]  trg_cnt,
  output logic              bus_wd_req,
  output logic [31:0]       bus_wd_data,
  output logic              rd_data_acc
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic wr_ctrl, wr_fctrl, wr_rptr, wr_trg;
  logic [31:0] rd_mux;

  assign wr_ctrl     = bus_wr && hit(bus_addr, OFS_CTRL);
  assign wr_fctrl    = bus_wr && hit(bus_addr, OFS_FCTRL);
  assign wr_rptr     = bus_wr && hit(bus_addr, OFS_RPTR);
  assign wr_trg      = bus_wr && hit(bus_addr, OFS_TRGCNT);
  assign wptr_load   = bus_wr && hit(bus_addr, OFS_WPTR);
  assign wptr_val    = bus_wdata[AW-1:0];
  assign bus_wd_req  = bus_wr && hit(bus_addr, OFS_WDATA);
  assign bus_wd_data = bus_wdata;
  assign en_rise     = wr_ctrl && bus_wdata[0] && !ctl_en;
  assign flush_set   = wr_fctrl && bus_wdata[FCTRL_FLUSH_BIT];
  assign rd_data_acc = bus_rd && hit(bus_addr, OFS_RDATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en        <= 1'b0;
      stop_on_trig  <= 1'b0;
      stop_on_flush <= 1'b0;
      trg_cnt       <= '0;
    end else begin
      if (wr_ctrl) ctl_en <= bus_wdata[0];
      if (wr_trg) trg_cnt <= bus_wdata[TRG_W-1:0];
      if (wr_fctrl) begin
        stop_on_trig  <= bus_wdata[FCTRL_STOPTRG_BIT];
        stop_on_flush <= bus_wdata[FCTRL_STOPFL_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rptr <= '0;
    else if (wr_rptr) rptr <= bus_wdata[AW-1:0];
    else if (rd_data_acc) rptr <= rptr + 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (hit(bus_addr, OFS_DEPTH))       rd_mux = 32'(DEPTH);
    else if (hit(bus_addr, OFS_STAT))   rd_mux = {31'b0, full};
    else if (hit(bus_addr, OFS_RDATA))  rd_mux = ram_q;
    else if (hit(bus_addr, OFS_RPTR))   rd_mux = 32'(rptr);
    else if (hit(bus_addr, OFS_WPTR))   rd_mux = 32'(wptr);
    else if (hit(bus_addr, OFS_TRGCNT)) rd_mux = 32'(trg_cnt);
    else if (hit(bus_addr, OFS_CTRL))   rd_mux = {31'b0, ctl_en};
    else if (hit(bus_addr, OFS_FSTAT))  rd_mux = 32'(stopped) << FSTAT_STOPPED_BIT;
    else if (hit(bus_addr, OFS_FCTRL))  rd_mux = fctrl_word(stop_on_trig, stop_on_flush, flush_busy);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/trs_capture_ctrl.sv
module trs_capture_ctrl
  import trs_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int TRG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic             en_rise,
  input  logic             stop_on_trig,
  input  logic             stop_on_flush,
  input  logic             flush_set,
  input  logic [TRG_W-1:0] trg_cnt,
  input  logic             trc_valid,
  input  logic [31:0]      trc_data,
  input  logic             trig_in,
  input  logic             bus_wd_req,
  input  logic [31:0]      bus_wd_data,
  input  logic             wptr_load,
  input  logic [AW-1:0]    wptr_val,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output logic [31:0]      ram_wdata,
  output logic [AW-1:0]    wptr,
  output logic             full,
  output logic             stopped,
  output logic             flush_busy,
  output logic             ev_store,
  output logic             ev_pad,
  output logic             ev_trig,
  output logic             ev_finish
);
  cap_state_e       state;
  logic             trig_seen, pad_for_trig;
  logic [TRG_W-1:0] remain;
  logic             cap_live, trig_done, go_pad, ev_bus_wr;

  assign cap_live  = ctl_en && !stopped;
  assign trig_done = trig_seen && (remain == '0);
  assign go_pad    = (state == ST_RUN) && (flush_busy || (cap_live && trig_done));
  assign ev_store  = (state == ST_RUN) && !go_pad && cap_live && trc_valid;
  assign ev_trig   = (state == ST_RUN) && !go_pad && cap_live && stop_on_trig
                     && !trig_seen && trig_in;
  assign ev_pad    = (state == ST_PAD) && cap_live && !on_frame_edge(32'(wptr));
  assign ev_finish = (state == ST_PAD) && !ev_pad;
  assign ev_bus_wr = bus_wd_req && !cap_live;

  assign ram_we    = ev_store || ev_pad || ev_bus_wr;
  assign ram_waddr = wptr;
  assign ram_wdata = ev_store ? trc_data : (ev_bus_wr ? bus_wd_data : 32'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      full <= 1'b0;
    end else if (wptr_load) begin
      wptr <= wptr_val;
      full <= 1'b0;
    end else if (ram_we) begin
      wptr <= wptr + 1'b1;
      if (wptr == AW'(DEPTH - 1)) full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_RUN;
      pad_for_trig <= 1'b0;
    end else if (go_pad) begin
      state        <= ST_PAD;
      pad_for_trig <= cap_live && trig_done;
    end else if (ev_finish) begin
      state        <= ST_RUN;
      pad_for_trig <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_seen <= 1'b0;
      remain    <= '0;
    end else if (en_rise) begin
      trig_seen <= 1'b0;
      remain    <= '0;
    end else if (ev_trig) begin
      trig_seen <= 1'b1;
      remain    <= trg_cnt;
    end else if (ev_store && trig_seen && remain != '0) begin
      remain    <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stopped <= 1'b0;
    else if (en_rise) stopped <= 1'b0;
    else if (ev_finish && (pad_for_trig || (flush_busy && stop_on_flush))) stopped <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flush_busy <= 1'b0;
    else if (flush_set) flush_busy <= 1'b1;
    else if (ev_finish) flush_busy <= 1'b0;
  end
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trs_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int TRG_W  = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              trc_valid,
  input  logic [31:0]       trc_data,
  input  logic              trig_in,
  input  logic              flush_req
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0]    wptr, rptr, wptr_val, ram_waddr;
  logic             full, stopped, flush_busy;
  logic             ctl_en, en_rise, stop_on_trig, stop_on_flush, flush_set_bus, flush_set;
  logic             wptr_load, bus_wd_req, rd_data_acc, ram_we;
  logic [TRG_W-1:0] trg_cnt;
  logic [31:0]      bus_wd_data, ram_q, ram_wdata;
  logic             ev_store, ev_pad, ev_trig, ev_finish;

  assign flush_set = flush_set_bus || flush_req;

  trs_regfile #(.DEPTH(DEPTH), .AW(AW), .TRG_W(TRG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wptr(wptr), .full(full),
    .stopped(stopped), .flush_busy(flush_busy), .ram_q(ram_q), .rptr(rptr),
    .ctl_en(ctl_en), .en_rise(en_rise), .stop_on_trig(stop_on_trig),
    .stop_on_flush(stop_on_flush), .flush_set(flush_set_bus), .wptr_load(wptr_load),
    .wptr_val(wptr_val), .trg_cnt(trg_cnt), .bus_wd_req(bus_wd_req),
    .bus_wd_data(bus_wd_data), .rd_data_acc(rd_data_acc)
  );

  trs_capture_ctrl #(.DEPTH(DEPTH), .AW(AW), .TRG_W(TRG_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .en_rise(en_rise),
    .stop_on_trig(stop_on_trig), .stop_on_flush(stop_on_flush), .flush_set(flush_set),
    .trg_cnt(trg_cnt), .trc_valid(trc_valid), .trc_data(trc_data), .trig_in(trig_in),
    .bus_wd_req(bus_wd_req), .bus_wd_data(bus_wd_data), .wptr_load(wptr_load),
    .wptr_val(wptr_val), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .wptr(wptr), .full(full), .stopped(stopped), .flush_busy(flush_busy),
    .ev_store(ev_store), .ev_pad(ev_pad), .ev_trig(ev_trig), .ev_finish(ev_finish)
  );

  trs_ring_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rptr), .rdata(ram_q)
  );
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr,
  input logic          full,
  input logic          stopped,
  input logic          flush_busy,
  input logic          ram_we,
  input logic          wptr_load,
  input logic          rd_data_acc,
  input logic          ctl_en
);
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !wptr_load) |=> (wptr == AW'($past(wptr) + 1'b1))); // R2
  AST_FULL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !wptr_load && wptr == AW'(DEPTH - 1)) |=> full); // R3
  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_load |=> !full); // R3
  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_acc |=> (rptr == AW'($past(rptr) + 1'b1))); // R5
  AST_STOP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stopped) && $past(ctl_en)) |-> (wptr[1:0] == 2'b00)); // R6
  AST_FLUSH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flush_busy) && $past(ctl_en && !stopped)) |-> (wptr[1:0] == 2'b00)); // R7
endmodule

bind trace_ring_sink trs_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wptr(wptr), .rptr(rptr), .full(full), .stopped(stopped),
  .flush_busy(flush_busy), .ram_we(ram_we), .wptr_load(wptr_load),
  .rd_data_acc(rd_data_acc), .ctl_en(ctl_en)
);

// File: tb/tb_trace_ring_sink.sv
module tb_trace_ring_sink;
  localparam int D = 64;
  localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_RDATA = 12'h010,
                          A_RPTR = 12'h014, A_WPTR = 12'h018, A_TRG = 12'h01C,
                          A_CTRL = 12'h020, A_WDATA = 12'h024, A_FSTAT = 12'h300,
                          A_FCTRL = 12'h304;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, trc_valid = 1'b0, trig_in = 1'b0, flush_req = 1'b0;
  logic [31:0] bus_wdata = '0, trc_data = '0, bus_rdata;

  int n_checks = 0, n_fail = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  trace_ring_sink dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trc_valid(trc_valid),
    .trc_data(trc_data), .trig_in(trig_in), .flush_req(flush_req));

  // behavioural reference model
  int m_mem [D];
  int m_wptr, m_rptr, m_remain, m_trg;
  bit m_full, m_en, m_stop, m_tseen, m_stoptrg, m_stopfl, m_fbusy, m_pad, m_padtrig;
  logic [31:0] m_rdata;
  bit live, tdone;

  function automatic logic [31:0] model_reg(input logic [11:0] a);
    case (a)
      A_DEPTH: return 32'(D);
      A_STAT:  return {31'b0, m_full};
      A_RDATA: return m_mem[m_rptr];
      A_RPTR:  return 32'(m_rptr);
      A_WPTR:  return 32'(m_wptr);
      A_TRG:   return 32'(m_trg);
      A_CTRL:  return {31'b0, m_en};
      A_FSTAT: return m_stop ? 32'h2 : 32'h0;
      A_FCTRL: return (m_stoptrg ? 32'h2000 : 0) | (m_stopfl ? 32'h1000 : 0) | (m_fbusy ? 32'h40 : 0);
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_store(input logic [31:0] d);
    m_mem[m_wptr] = d;
    if (m_wptr == D - 1) m_full = 1'b1;
    m_wptr = (m_wptr + 1) % D;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wptr = 0; m_rptr = 0; m_remain = 0; m_trg = 0; m_full = 0; m_en = 0; m_stop = 0;
      m_tseen = 0; m_stoptrg = 0; m_stopfl = 0; m_fbusy = 0; m_pad = 0; m_padtrig = 0;
      m_rdata = '0;
    end else begin
      live  = m_en && !m_stop;
      tdone = m_tseen && m_remain == 0;
      if (bus_rd) begin
        m_rdata = model_reg(bus_addr);
        if (bus_addr == A_RDATA) m_rptr = (m_rptr + 1) % D;
      end
      if (!m_pad) begin
        if (m_fbusy || (live && tdone)) begin
          m_pad = 1; m_padtrig = live && tdone;
        end else if (live) begin
          if (trc_valid) begin
            m_store(trc_data);
            if (m_tseen && m_remain > 0) m_remain--;
          end
          if (m_stoptrg && !m_tseen && trig_in) begin m_tseen = 1; m_remain = m_trg; end
        end
      end else begin
        if (live && (m_wptr % 4) != 0) m_store(32'h0);
        else begin
          if (m_padtrig || (m_fbusy && m_stopfl)) m_stop = 1;
          m_fbusy = 0; m_pad = 0; m_padtrig = 0;
        end
      end
      if (bus_wr) begin
        case (bus_addr)
          A_WDATA: if (!live) m_store(bus_wdata);
          A_WPTR:  begin m_wptr = int'(bus_wdata) % D; m_full = 0; end
          A_RPTR:  m_rptr = int'(bus_wdata) % D;
          A_TRG:   m_trg = int'(bus_wdata & 32'hFFFF);
          A_CTRL:  begin
            if (bus_wdata[0] && !m_en) begin m_stop = 0; m_tseen = 0; m_remain = 0; end
            m_en = bus_wdata[0];
          end
          A_FCTRL: begin
            m_stoptrg = bus_wdata[13]; m_stopfl = bus_wdata[12];
            if (bus_wdata[6]) m_fbusy = 1;
          end
          default: ;
        endcase
      end
      if (flush_req) m_fbusy = 1;
    end
  end

  // every-clock comparison of the registered read port
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      if (bus_rdata !== m_rdata) begin
        n_fail++;
        $display("FAIL %s model compare: actual %h expected %h", phase, bus_rdata, m_rdata);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    n_checks++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr %h: actual %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic send(input int n, input logic [31:0] base, input int trig_idx, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); trc_valid = 1; trc_data = base + i; trig_in = (i == trig_idx);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); trc_valid = 0; trig_in = 0;
      end
    end
    @(negedge clk); trc_valid = 0; trig_in = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd_chk(A_DEPTH, 32'd64, "R1"); rd_chk(A_STAT, 0, "R1"); rd_chk(A_WPTR, 0, "R1");
    rd_chk(A_RPTR, 0, "R1"); rd_chk(A_CTRL, 0, "R1"); rd_chk(A_FSTAT, 0, "R1");
    rd_chk(A_FCTRL, 0, "R1");
    // R4 clear RAM through the data port; R3 full on wrap
    phase = "R4";
    wr(A_WPTR, 0);
    for (int i = 0; i < D; i++) wr(A_WDATA, 0);
    rd_chk(A_STAT, 1, "R3"); rd_chk(A_WPTR, 0, "R4");
    wr(A_WPTR, 0); rd_chk(A_STAT, 0, "R3");
    wr(A_WPTR, 60);
    for (int i = 0; i < 5; i++) wr(A_WDATA, 32'hA0 + i);
    rd_chk(A_WPTR, 1, "R4"); rd_chk(A_STAT, 1, "R3");
    // R5 readback across the wrap
    phase = "R5";
    wr(A_RPTR, 60);
    for (int i = 0; i < 5; i++) rd_chk(A_RDATA, 32'hA0 + i, "R5");
    rd_chk(A_RPTR, 1, "R5");
    wr(A_WPTR, 0);
    // R2 capture with gaps, then dropped while disabled
    phase = "R2";
    wr(A_CTRL, 1);
    send(10, 32'h1000, -1, 2);
    wr(A_CTRL, 0);
    rd_chk(A_WPTR, 10, "R2");
    send(3, 32'h2000, -1, 0);
    rd_chk(A_WPTR, 10, "R2");
    wr(A_RPTR, 0);
    for (int i = 0; i < 10; i++) rd_chk(A_RDATA, 32'h1000 + i, "R2");
    // R4 data write ignored while live
    phase = "R4";
    wr(A_CTRL, 1); wr(A_WDATA, 32'hDEAD); rd_chk(A_WPTR, 10, "R4");
    // R7 flush from an unaligned pointer
    phase = "R7";
    wr(A_FCTRL, 32'h40);
    rd_chk(A_FCTRL, 32'h40, "R7");
    idle(6);
    rd_chk(A_FCTRL, 0, "R7"); rd_chk(A_WPTR, 12, "R7"); rd_chk(A_FSTAT, 0, "R7");
    wr(A_RPTR, 10); rd_chk(A_RDATA, 0, "R7"); rd_chk(A_RDATA, 0, "R7");
    @(negedge clk); flush_req = 1; @(negedge clk); flush_req = 0;
    idle(4);
    rd_chk(A_FCTRL, 0, "R7"); rd_chk(A_WPTR, 12, "R7");
    // R8 stop on flush
    phase = "R8";
    send(1, 32'h3000, -1, 0);
    wr(A_FCTRL, 32'h1040);
    idle(6);
    rd_chk(A_FSTAT, 2, "R8"); rd_chk(A_WPTR, 16, "R8");
    send(4, 32'h3100, -1, 0);
    rd_chk(A_WPTR, 16, "R8");
    // R9 re-enable clears stop
    phase = "R9";
    wr(A_FCTRL, 0); wr(A_CTRL, 0); wr(A_CTRL, 1);
    rd_chk(A_FSTAT, 0, "R9");
    send(2, 32'h4000, -1, 0);
    rd_chk(A_WPTR, 18, "R9");
    // R10 trigger ignored without stop-on-trigger
    phase = "R10";
    wr(A_TRG, 2);
    send(8, 32'h5000, 1, 0);
    rd_chk(A_WPTR, 26, "R10"); rd_chk(A_FSTAT, 0, "R10");
    // R6 stop after trigger count, padded to frame
    phase = "R6";
    wr(A_TRG, 5); wr(A_FCTRL, 32'h2000);
    send(20, 32'h6000, 3, 0);
    rd_chk(A_WPTR, 36, "R6"); rd_chk(A_FSTAT, 2, "R6");
    wr(A_RPTR, 34);
    rd_chk(A_RDATA, 32'h6008, "R6"); rd_chk(A_RDATA, 0, "R6");
    // R3 wrap during live capture
    phase = "R3";
    wr(A_FCTRL, 0); wr(A_CTRL, 0); wr(A_CTRL, 1); wr(A_WPTR, 60);
    send(6, 32'h7000, -1, 0);
    rd_chk(A_WPTR, 2, "R3"); rd_chk(A_STAT, 1, "R3");
    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule